// File: doc/BRIEF.md
# BCD calendar timekeeping counter

This block keeps wall-clock time and calendar date as seven packed-BCD bytes: seconds, minutes, hours, day of week, date, month and a two-digit year. A one-cycle pulse on the tick input stands for one elapsed second. On each tick the seconds field advances, and carries ripple through minutes, hours and the calendar fields. Month lengths and leap Februaries are handled in hardware. Mode flags sit in spare bits of the same bytes as the counts. A halt flag shares the seconds byte, and a 12/24-hour select and a PM flag share the hours byte. The counting logic obeys these flags.

A host writes any single register through a byte-wide load port, selected by a 3-bit index. A combinational read port returns any register in its packed form. A load that lands in the same cycle as a tick wins for the register it targets. Every other register still advances from its value before that edge. Bits that carry no meaning are dropped when written and read back as zero.

Top module: `bcd_rtc_calendar`

## Requirements
- R1: After synchronous reset the registers read seconds 0x00, minutes 0x00, hours 0x00 (24-hour), day of week 0x01, date 0x01, month 0x01 and year 0x00.
- R2: Seconds (index 0, bits 6:0) and minutes (index 1, bits 6:0) count 00 to 59 in BCD. On each tick, seconds advance. Passing 59 returns a field to 00 and advances the next field by one.
- R3: While bit 7 of index 0 (halt) is 1, ticks change no register. After the flag is cleared, counting resumes from the held value.
- R4: With bit 6 of index 2 clear, hours count 00 to 23 in BCD in bits 5:0. Passing 23 returns hours to 00 and advances the day.
- R5: With bit 6 of index 2 set, bits 4:0 hold hours 01 to 12 in BCD and bit 5 is PM (1 = PM). Hour 11 goes to 12 and toggles PM. Hour 12 goes to 01 without a toggle. The day advances only when 11 PM becomes 12 AM.
- R6: Day of week (index 3, bits 2:0) advances with each new day, wrapping from 7 to 1.
- R7: Date (index 4, bits 5:0) returns to 01 and advances the month after the last day of the month. The last day is 30 for months 04, 06, 09 and 11, and 31 for the other months. For February it is 29 when the year value is a multiple of 4, and 28 otherwise.
- R8: Month (index 5, bits 4:0) wraps from 12 to 01 and advances the year. Year (index 6, full byte) wraps from 99 to 00.
- R9: When the load enable is high, the load data is written at the next edge into the register chosen by the load index (0 to 6, order as above). In the same cycle this overrides a tick increment for that register, while other registers advance as if no load had occurred.
- R10: The read port returns the register chosen by the read index combinationally. Bits read as zero outside these masks: 0xFF, 0x7F, 0x7F, 0x07, 0x3F, 0x1F and 0xFF for indices 0 to 6. Index 7 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-second advance pulse |
| ld_en_i | input | 1 | Register load strobe |
| ld_idx_i | input | 3 | Register selected for loading |
| ld_data_i | input | 8 | Packed value to load |
| rd_idx_i | input | 3 | Register selected for reading |
| rd_data_o | output | 8 | Packed value of selected register |

## Verification
Directed sequences preset each field one step short of its rollover and apply a single tick. They tell apart 30-day, 31-day, leap and common Februaries, December-into-new-year, and the three distinct 12-hour transitions, including which one carries into the date. Halt sequences apply a run of ticks to a frozen clock and then a tick after release. Collision cases load one register while a tick moves the others. Constrained-random loads biased toward edge values, mixed with random tick trains, are compared on every register against a calendar model kept in whole-number arithmetic. This exposes carry-chain and mode-flag mistakes that the directed cases miss.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    localparam int BYTE_W   = 8;
    localparam int IDX_W    = 3;
    localparam int NUM_REGS = 7;

    typedef logic [BYTE_W-1:0] bcd8_t;

    typedef enum logic [IDX_W-1:0] {
        RI_SEC   = 3'd0,
        RI_MIN   = 3'd1,
        RI_HOUR  = 3'd2,
        RI_DOW   = 3'd3,
        RI_DATE  = 3'd4,
        RI_MONTH = 3'd5,
        RI_YEAR  = 3'd6
    } reg_idx_e;

    typedef struct packed {
        bcd8_t hour;
        bcd8_t min;
        bcd8_t sec;
    } hms_t;

    typedef struct packed {
        bcd8_t year;
        bcd8_t month;
        bcd8_t date;
        bcd8_t dow;
    } ymd_t;

    // two-digit BCD step without range wrap
    function automatic bcd8_t bcd_inc(bcd8_t v);
        bcd8_t r;
        if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'h0};
        else                r = {v[7:4], v[3:0] + 4'd1};
        return r;
    endfunction

    // year value modulo 4 from BCD digits: 10T+U == 2T+U (mod 4)
    function automatic logic is_leap(bcd8_t y);
        logic [5:0] s;
        s = {1'b0, y[7:4], 1'b0} + {2'b00, y[3:0]};
        return (s[1:0] == 2'b00);
    endfunction

    function automatic bcd8_t last_day(bcd8_t m, logic leap);
        bcd8_t r;
        case (m)
            8'h02:                      r = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
            default:                    r = 8'h31;
        endcase
        return r;
    endfunction

    function automatic bcd8_t keep_mask(logic [IDX_W-1:0] i);
        bcd8_t r;
        case (i)
            RI_SEC:   r = 8'hFF;
            RI_MIN:   r = 8'h7F;
            RI_HOUR:  r = 8'h7F;
            RI_DOW:   r = 8'h07;
            RI_DATE:  r = 8'h3F;
            RI_MONTH: r = 8'h1F;
            RI_YEAR:  r = 8'hFF;
            default:  r = 8'h00;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rtc_hms_unit.sv
module rtc_hms_unit
    import rtc_cal_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  tick_i,
    input  logic  ld_sec_i,
    input  logic  ld_min_i,
    input  logic  ld_hour_i,
    input  bcd8_t ld_data_i,
    output hms_t  hms_o,
    output logic  day_step_o
);

    hms_t  cur, nxt;
    bcd8_t ts, tm, th;
    logic  adv, sec_wrap, min_wrap, min_step, hour_step, day_c;

    assign adv       = tick_i & ~cur.sec[7];
    assign sec_wrap  = cur.sec[6:0] >= 7'h59;
    assign min_wrap  = cur.min[6:0] >= 7'h59;
    assign min_step  = adv & sec_wrap;
    assign hour_step = min_step & min_wrap;

    always_comb begin
        ts = bcd_inc({1'b0, cur.sec[6:0]});
        tm = bcd_inc({1'b0, cur.min[6:0]});
        th = cur.hour[6] ? bcd_inc({3'b000, cur.hour[4:0]})
                         : bcd_inc({2'b00, cur.hour[5:0]});
        nxt.sec  = {cur.sec[7], sec_wrap ? 7'h00 : ts[6:0]};
        nxt.min  = {1'b0, min_wrap ? 7'h00 : tm[6:0]};
        day_c    = 1'b0;
        if (cur.hour[6]) begin
            if (cur.hour[4:0] == 5'h11) begin
                nxt.hour = {2'b01, ~cur.hour[5], 5'h12};
                day_c    = cur.hour[5];
            end else if (cur.hour[4:0] >= 5'h12) begin
                nxt.hour = {2'b01, cur.hour[5], 5'h01};
            end else begin
                nxt.hour = {2'b01, cur.hour[5], th[4:0]};
            end
        end else begin
            if (cur.hour[5:0] >= 6'h23) begin
                nxt.hour = 8'h00;
                day_c    = 1'b1;
            end else begin
                nxt.hour = {2'b00, th[5:0]};
            end
        end
    end

    assign day_step_o = hour_step & day_c;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else begin
            if (ld_sec_i)       cur.sec  <= ld_data_i;
            else if (adv)       cur.sec  <= nxt.sec;
            if (ld_min_i)       cur.min  <= ld_data_i;
            else if (min_step)  cur.min  <= nxt.min;
            if (ld_hour_i)      cur.hour <= ld_data_i;
            else if (hour_step) cur.hour <= nxt.hour;
        end
    end

    assign hms_o = cur;

    // R3
    halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cur.sec[7] && !ld_sec_i && !ld_min_i && !ld_hour_i) |=> $stable(cur));

    // R5
    twelve_roll_chk: assert property (@(posedge clk) disable iff (rst)
        (hour_step && cur.hour[6] && cur.hour[4:0] == 5'h11 && !ld_hour_i)
        |=> (cur.hour[4:0] == 5'h12 && cur.hour[5] != $past(cur.hour[5])));

    // R4
    day_roll_chk: assert property (@(posedge clk) disable iff (rst)
        (hour_step && !cur.hour[6] && cur.hour[5:0] == 6'h23 && !ld_hour_i)
        |=> (cur.hour == 8'h00));

    // R9
    sec_load_chk: assert property (@(posedge clk) disable iff (rst)
        ld_sec_i |=> (cur.sec == $past(ld_data_i)));

endmodule

// File: rtl/rtc_ymd_unit.sv
module rtc_ymd_unit
    import rtc_cal_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  day_step_i,
    input  logic  ld_dow_i,
    input  logic  ld_date_i,
    input  logic  ld_month_i,
    input  logic  ld_year_i,
    input  bcd8_t ld_data_i,
    output ymd_t  ymd_o
);

    ymd_t  cur, nxt;
    bcd8_t dim, td, tmo, ty;
    logic  date_wrap, month_wrap, mon_step, year_step;

    assign dim        = last_day(cur.month, is_leap(cur.year));
    assign date_wrap  = cur.date >= dim;
    assign month_wrap = cur.month >= 8'h12;
    assign mon_step   = day_step_i & date_wrap;
    assign year_step  = mon_step & month_wrap;

    always_comb begin
        td  = bcd_inc(cur.date);
        tmo = bcd_inc(cur.month);
        ty  = bcd_inc(cur.year);
        nxt.dow   = (cur.dow[2:0] >= 3'd7) ? 8'h01 : {5'b0, cur.dow[2:0] + 3'd1};
        nxt.date  = date_wrap  ? 8'h01 : td;
        nxt.month = month_wrap ? 8'h01 : tmo;
        nxt.year  = (cur.year >= 8'h99) ? 8'h00 : ty;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur.dow   <= 8'h01;
            cur.date  <= 8'h01;
            cur.month <= 8'h01;
            cur.year  <= 8'h00;
        end else begin
            if (ld_dow_i)        cur.dow   <= ld_data_i;
            else if (day_step_i) cur.dow   <= nxt.dow;
            if (ld_date_i)       cur.date  <= ld_data_i;
            else if (day_step_i) cur.date  <= nxt.date;
            if (ld_month_i)      cur.month <= ld_data_i;
            else if (mon_step)   cur.month <= nxt.month;
            if (ld_year_i)       cur.year  <= ld_data_i;
            else if (year_step)  cur.year  <= nxt.year;
        end
    end

    assign ymd_o = cur;

    // R6
    dow_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (day_step_i && cur.dow[2:0] == 3'd7 && !ld_dow_i) |=> (cur.dow == 8'h01));

    // R8
    year_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (year_step && cur.year == 8'h99 && !ld_year_i) |=> (cur.year == 8'h00));

    // R7
    feb_common_chk: assert property (@(posedge clk) disable iff (rst)
        (day_step_i && cur.month == 8'h02 && cur.date == 8'h28 && !is_leap(cur.year)
         && !ld_date_i && !ld_month_i) |=> (cur.date == 8'h01 && cur.month == 8'h03));

endmodule

// File: rtl/bcd_rtc_calendar.sv
module bcd_rtc_calendar
    import rtc_cal_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             ld_en_i,
    input  logic [IDX_W-1:0] ld_idx_i,
    input  logic [BYTE_W-1:0] ld_data_i,
    input  logic [IDX_W-1:0] rd_idx_i,
    output logic [BYTE_W-1:0] rd_data_o
);

    logic [NUM_REGS-1:0] ld_sel;
    bcd8_t               ld_val;
    hms_t                hms;
    ymd_t                ymd;
    logic                day_step;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_ld_dec
        assign ld_sel[g] = ld_en_i && (ld_idx_i == IDX_W'(g));
    end

    assign ld_val = ld_data_i & keep_mask(ld_idx_i);

    rtc_hms_unit u_hms (
        .clk        (clk),
        .rst        (rst),
        .tick_i     (tick_i),
        .ld_sec_i   (ld_sel[RI_SEC]),
        .ld_min_i   (ld_sel[RI_MIN]),
        .ld_hour_i  (ld_sel[RI_HOUR]),
        .ld_data_i  (ld_val),
        .hms_o      (hms),
        .day_step_o (day_step)
    );

    rtc_ymd_unit u_ymd (
        .clk        (clk),
        .rst        (rst),
        .day_step_i (day_step),
        .ld_dow_i   (ld_sel[RI_DOW]),
        .ld_date_i  (ld_sel[RI_DATE]),
        .ld_month_i (ld_sel[RI_MONTH]),
        .ld_year_i  (ld_sel[RI_YEAR]),
        .ld_data_i  (ld_val),
        .ymd_o      (ymd)
    );

    always_comb begin
        case (rd_idx_i)
            RI_SEC:   rd_data_o = hms.sec;
            RI_MIN:   rd_data_o = hms.min;
            RI_HOUR:  rd_data_o = hms.hour;
            RI_DOW:   rd_data_o = ymd.dow;
            RI_DATE:  rd_data_o = ymd.date;
            RI_MONTH: rd_data_o = ymd.month;
            RI_YEAR:  rd_data_o = ymd.year;
            default:  rd_data_o = 8'h00;
        endcase
    end

endmodule

// File: tb/tb_bcd_rtc_calendar.sv
module tb_bcd_rtc_calendar;

    localparam int CLK_PERIOD = 10;
    localparam int WDOG_LIMIT = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_i = 1'b0;
    logic       ld_en_i = 1'b0;
    logic [2:0] ld_idx_i = '0;
    logic [7:0] ld_data_i = '0;
    logic [2:0] rd_idx_i = '0;
    logic [7:0] rd_data_o;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    logic [7:0] mdl [0:6];

    always #(CLK_PERIOD/2) clk = ~clk;

    bcd_rtc_calendar dut (
        .clk(clk), .rst(rst), .tick_i(tick_i), .ld_en_i(ld_en_i),
        .ld_idx_i(ld_idx_i), .ld_data_i(ld_data_i),
        .rd_idx_i(rd_idx_i), .rd_data_o(rd_data_o)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WDOG_LIMIT) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=%0d cycles expected<%0d", cyc, WDOG_LIMIT);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    function automatic int b2i(logic [7:0] v);
        return int'(v[7:4]) * 10 + int'(v[3:0]);
    endfunction

    function automatic logic [7:0] i2b(int n);
        logic [7:0] r;
        r[7:4] = 4'(n / 10);
        r[3:0] = 4'(n % 10);
        return r;
    endfunction

    function automatic int month_len(int m, int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    function automatic logic [7:0] mask_of(int i);
        case (i)
            0: return 8'hFF; 1: return 8'h7F; 2: return 8'h7F; 3: return 8'h07;
            4: return 8'h3F; 5: return 8'h1F; 6: return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction

    function automatic string tag_of(int i);
        case (i)
            0, 1: return "R2";
            2: return "R4";
            3: return "R6";
            4: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic model_tick();
        int s, m, h, dw, d, mo, y;
        bit halt, pm, c_m, c_h, c_d, c_mo, c_y;
        if (mdl[0][7]) return;
        halt = mdl[0][7];
        s = b2i(mdl[0] & 8'h7F); m = b2i(mdl[1]);
        dw = int'(mdl[3]); d = b2i(mdl[4]); mo = b2i(mdl[5]); y = b2i(mdl[6]);
        c_h = 0; c_d = 0; c_mo = 0; c_y = 0;
        c_m = (s >= 59); s = c_m ? 0 : s + 1;
        if (c_m) begin c_h = (m >= 59); m = c_h ? 0 : m + 1; end
        if (c_h) begin
            if (mdl[2][6]) begin
                h = b2i(mdl[2] & 8'h1F); pm = mdl[2][5];
                if (h == 11) begin h = 12; c_d = pm; pm = ~pm; end
                else if (h >= 12) h = 1;
                else h = h + 1;
                mdl[2] = i2b(h) | 8'h40 | (pm ? 8'h20 : 8'h00);
            end else begin
                h = b2i(mdl[2] & 8'h3F);
                if (h >= 23) begin h = 0; c_d = 1; end else h = h + 1;
                mdl[2] = i2b(h);
            end
        end
        if (c_d) begin
            dw = (dw >= 7) ? 1 : dw + 1;
            if (d >= month_len(mo, y)) begin d = 1; c_mo = 1; end else d = d + 1;
        end
        if (c_mo) begin
            if (mo >= 12) begin mo = 1; c_y = 1; end else mo = mo + 1;
        end
        if (c_y) y = (y >= 99) ? 0 : y + 1;
        mdl[0] = i2b(s) | (halt ? 8'h80 : 8'h00);
        mdl[1] = i2b(m);
        mdl[3] = 8'(dw); mdl[4] = i2b(d); mdl[5] = i2b(mo); mdl[6] = i2b(y);
    endtask

    task automatic cycle(bit tk, bit le, int idx, logic [7:0] dat);
        @(negedge clk);
        tick_i = tk; ld_en_i = le; ld_idx_i = 3'(idx); ld_data_i = dat;
        @(posedge clk);
        #1;
        tick_i = 1'b0; ld_en_i = 1'b0;
        if (tk) model_tick();
        if (le && idx < 7) mdl[idx] = dat & mask_of(idx);
    endtask

    task automatic load(int idx, logic [7:0] dat);
        cycle(1'b0, 1'b1, idx, dat);
    endtask

    task automatic tick1();
        cycle(1'b1, 1'b0, 0, 8'h00);
    endtask

    task automatic check_val(int idx, logic [7:0] exp, string tag);
        rd_idx_i = 3'(idx);
        #1;
        checks++;
        if (rd_data_o !== exp) begin
            failures++;
            $display("FAIL %s reg%0d: actual=%02h expected=%02h", tag, idx, rd_data_o, exp);
        end
    endtask

    task automatic check_model(string tag);
        for (int i = 0; i < 7; i++) check_val(i, mdl[i], tag);
    endtask

    task automatic set_all(logic [7:0] hh, logic [7:0] mm, logic [7:0] ss,
                           logic [7:0] dw, logic [7:0] dd, logic [7:0] mo, logic [7:0] yy);
        load(0, ss); load(1, mm); load(2, hh);
        load(3, dw); load(4, dd); load(5, mo); load(6, yy);
    endtask

    function automatic logic [7:0] rand_val(int idx);
        int v;
        case (idx)
            0: begin
                v = ($urandom % 2 == 0) ? 57 + int'($urandom % 3) : int'($urandom % 60);
                return i2b(v) | (($urandom % 8 == 0) ? 8'h80 : 8'h00);
            end
            1: begin
                v = ($urandom % 2 == 0) ? 59 : int'($urandom % 60);
                return i2b(v);
            end
            2: begin
                if ($urandom % 2 == 0) begin
                    v = ($urandom % 2 == 0) ? 11 + int'($urandom % 2) : 1 + int'($urandom % 12);
                    return i2b(v) | 8'h40 | (($urandom % 2 == 0) ? 8'h20 : 8'h00);
                end
                v = ($urandom % 2 == 0) ? 23 : int'($urandom % 24);
                return i2b(v);
            end
            3: return 8'(1 + $urandom % 7);
            4: begin
                v = ($urandom % 2 == 0) ? 28 : 1 + int'($urandom % 28);
                return i2b(v);
            end
            5: return i2b(1 + int'($urandom % 12));
            default: return i2b(int'($urandom % 100));
        endcase
    endfunction

    initial begin
        void'($urandom(32'h5EED_2024));
        for (int i = 0; i < 7; i++) mdl[i] = 8'h00;
        mdl[3] = 8'h01; mdl[4] = 8'h01; mdl[5] = 8'h01;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;

        // R1 reset values
        check_val(0, 8'h00, "R1"); check_val(1, 8'h00, "R1"); check_val(2, 8'h00, "R1");
        check_val(3, 8'h01, "R1"); check_val(4, 8'h01, "R1"); check_val(5, 8'h01, "R1");
        check_val(6, 8'h00, "R1");

        // R2 seconds and minutes carry
        set_all(8'h05, 8'h59, 8'h58, 8'h02, 8'h10, 8'h03, 8'h15);
        tick1();
        check_val(0, 8'h59, "R2");
        tick1();
        check_val(0, 8'h00, "R2"); check_val(1, 8'h00, "R2"); check_val(2, 8'h06, "R2");

        // R3 halt freezes, release resumes
        load(1, 8'h59); load(0, 8'hD9);
        repeat (5) tick1();
        check_val(0, 8'hD9, "R3"); check_val(1, 8'h59, "R3"); check_val(2, 8'h06, "R3");
        load(0, 8'h20);
        tick1();
        check_val(0, 8'h21, "R3"); check_val(1, 8'h59, "R3");

        // R4 24-hour midnight
        set_all(8'h23, 8'h59, 8'h59, 8'h03, 8'h10, 8'h05, 8'h21);
        tick1();
        check_val(2, 8'h00, "R4"); check_val(0, 8'h00, "R4");
        check_val(3, 8'h04, "R4"); check_val(4, 8'h11, "R4");

        // R5 12-hour transitions
        set_all(8'h71, 8'h59, 8'h59, 8'h03, 8'h10, 8'h05, 8'h21);
        tick1();
        check_val(2, 8'h52, "R5"); check_val(4, 8'h11, "R5");
        load(1, 8'h59); load(0, 8'h59);
        tick1();
        check_val(2, 8'h41, "R5"); check_val(4, 8'h11, "R5");
        load(2, 8'h51); load(1, 8'h59); load(0, 8'h59);
        tick1();
        check_val(2, 8'h72, "R5"); check_val(4, 8'h11, "R5");

        // R6 weekday wrap
        set_all(8'h23, 8'h59, 8'h59, 8'h07, 8'h12, 8'h05, 8'h21);
        tick1();
        check_val(3, 8'h01, "R6");

        // R7 month lengths
        set_all(8'h23, 8'h59, 8'h59, 8'h01, 8'h28, 8'h02, 8'h24);
        tick1();
        check_val(4, 8'h29, "R7"); check_val(5, 8'h02, "R7");
        load(2, 8'h23); load(1, 8'h59); load(0, 8'h59);
        tick1();
        check_val(4, 8'h01, "R7"); check_val(5, 8'h03, "R7");
        set_all(8'h23, 8'h59, 8'h59, 8'h01, 8'h28, 8'h02, 8'h23);
        tick1();
        check_val(4, 8'h01, "R7"); check_val(5, 8'h03, "R7");
        set_all(8'h23, 8'h59, 8'h59, 8'h01, 8'h30, 8'h04, 8'h23);
        tick1();
        check_val(4, 8'h01, "R7"); check_val(5, 8'h05, "R7");
        set_all(8'h23, 8'h59, 8'h59, 8'h01, 8'h30, 8'h07, 8'h23);
        tick1();
        check_val(4, 8'h31, "R7"); check_val(5, 8'h07, "R7");

        // R8 new year wrap
        set_all(8'h23, 8'h59, 8'h59, 8'h05, 8'h31, 8'h12, 8'h99);
        tick1();
        check_val(4, 8'h01, "R8"); check_val(5, 8'h01, "R8"); check_val(6, 8'h00, "R8");

        // R9 load beats tick for its own register only
        load(0, 8'h30);
        cycle(1'b1, 1'b1, 0, 8'h45);
        check_val(0, 8'h45, "R9");
        load(0, 8'h59); load(1, 8'h10);
        cycle(1'b1, 1'b1, 1, 8'h42);
        check_val(1, 8'h42, "R9"); check_val(0, 8'h00, "R9");

        // R10 reserved bits and unused index
        load(3, 8'hFF);
        check_val(3, 8'h07, "R10");
        load(5, 8'hF1);
        check_val(5, 8'h11, "R10");
        check_val(7, 8'h00, "R10");
        load(3, 8'h02); load(5, 8'h06);

        // random mix against the model
        for (int n = 0; n < 400; n++) begin
            int idx;
            bit le, tk;
            idx = int'($urandom % 7);
            le  = ($urandom % 4 == 0);
            tk  = ($urandom % 5 != 0);
            cycle(tk, le, idx, rand_val(idx));
            if (n % 4 == 3) begin
                for (int i = 0; i < 7; i++) check_val(i, mdl[i], tag_of(i));
            end
        end
        check_model("R9");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule